// File: doc/BRIEF.md
# Self-Sizing Base Address Register

This block is a 32-bit relocatable window register for a peripheral. It has two jobs. First, it tells configuration software how large the peripheral's memory region is. Second, it takes a base address from that software and decodes bus addresses against the window.

Out of reset, the register holds a mask. Every bit that software may program reads as one, and every bit below the region size reads as zero. The count of trailing zeros therefore gives the region size. Software reads this mask, picks a base aligned to that size and writes it back. The write replaces the mask, so the size cannot be read again until the next reset.

Once a base has been written, the block compares each incoming bus address with it. On a match it asserts a hit and reports the byte offset inside the window. The region size is fixed by the parameter `SIZE_LOG2`, which gives log2 of the size in bytes. An elaboration-time check rejects any value outside 4 to 31.

Top module: `bar_window`

## Requirements
- R1: After reset, `rdata_o` reads the size mask: ones in bits 31 down to `SIZE_LOG2`, zeros in bits `SIZE_LOG2-1` down to 0. With the default `SIZE_LOG2`=16 this is 0xFFFF0000.
- R2: A write takes effect on the rising clock edge where `sel_i` and `we_i` are both high. If either is low at the edge, the stored value is unchanged.
- R3: Bits below `SIZE_LOG2` of the stored value are always zero, whatever `wdata_i` held. Bits at and above `SIZE_LOG2` take the written value.
- R4: After a write, `rdata_o` returns the programmed base, combinationally from the stored value. It keeps returning the base, not the mask, on later reads until reset.
- R5: `hit_o` stays low from reset until the first write.
- R6: Once a base has been written, `hit_o` is high exactly when `bus_addr_i[31:SIZE_LOG2]` equals the stored base in those bits. This makes the window run from base to base+2^`SIZE_LOG2`-1 inclusive.
- R7: `offset_o` equals `bus_addr_i` with bits at and above `SIZE_LOG2` cleared while `hit_o` is high, and is zero while `hit_o` is low.
- R8: Reset (`rst_ni` low, asynchronous) restores the size mask and clears the programmed state, including after earlier writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Register select |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (mask or programmed base) |
| bus_addr_i | input | 32 | Bus address to decode |
| hit_o | output | 1 | Address falls in the programmed window |
| offset_o | output | 32 | Byte offset within the window, zero without a hit |

## Verification
The hardest state to reach is a register that was programmed and then reset again. Only there can the bench show that the mask comes back and that decoding stops, even though the address on the bus still matches the old base.

The bench programs a base and confirms hits at the first and last byte of the window. It then asserts reset with that address still driven and checks that the mask reads back and `hit_o` drops. Random writes with unaligned data and partial strobes, mixed with addresses just inside and just outside the window, cover the masking and decode edges.

// File: rtl/bar_pkg.sv
package bar_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // ones at and above size_log2, zeros below
  function automatic word_t size_mask(input int unsigned size_log2);
    word_t m;
    for (int i = 0; i < WORD_W; i++) m[i] = (i >= size_log2);
    return m;
  endfunction
endpackage

// File: rtl/bar_store.sv
module bar_store
  import bar_pkg::*;
#(
  parameter int unsigned SIZE_LOG2 = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  word_t wdata_i,
  output word_t base_o,
  output logic  prog_o
);
  localparam word_t MASK = size_mask(SIZE_LOG2);

  word_t base_q;
  logic  prog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= MASK;
      prog_q <= 1'b0;
    end else if (wr_i) begin
      base_q <= wdata_i & MASK;
      prog_q <= 1'b1;
    end
  end

  assign base_o = base_q;
  assign prog_o = prog_q;

  p_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (base_q == ($past(wdata_i) & MASK)));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(base_q));
  p_low_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_q & ~MASK) == '0);
endmodule

// File: rtl/bar_decode.sv
module bar_decode
  import bar_pkg::*;
#(
  parameter int unsigned SIZE_LOG2 = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  prog_i,
  input  word_t base_i,
  input  word_t addr_i,
  output logic  hit_o,
  output word_t offset_o
);
  localparam word_t MASK = size_mask(SIZE_LOG2);

  logic upper_eq;
  assign upper_eq = addr_i[WORD_W-1:SIZE_LOG2] == base_i[WORD_W-1:SIZE_LOG2];
  assign hit_o    = prog_i && upper_eq;
  assign offset_o = hit_o ? (addr_i & ~MASK) : '0;

  p_no_hit_unprog_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_i |-> !hit_o);
  p_hit_match_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((addr_i & MASK) == base_i));
  p_offset_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (offset_o == '0));
endmodule

// File: rtl/bar_window.sv
module bar_window
  import bar_pkg::*;
#(
  parameter int unsigned SIZE_LOG2 = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sel_i,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic [31:0] bus_addr_i,
  output logic        hit_o,
  output logic [31:0] offset_o
);
  localparam word_t MASK = size_mask(SIZE_LOG2);

  if (SIZE_LOG2 < 4 || SIZE_LOG2 > 31) begin : g_bad_size
    $error("bar_window: SIZE_LOG2 must lie in 4..31");
  end

  word_t base;
  logic  prog;

  bar_store #(.SIZE_LOG2(SIZE_LOG2)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (sel_i & we_i),
    .wdata_i (wdata_i),
    .base_o  (base),
    .prog_o  (prog)
  );

  bar_decode #(.SIZE_LOG2(SIZE_LOG2)) u_decode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .prog_i   (prog),
    .base_i   (base),
    .addr_i   (bus_addr_i),
    .hit_o    (hit_o),
    .offset_o (offset_o)
  );

  assign rdata_o = base;

  // until programmed, the register must still show the size mask
  p_mask_unprog_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog |-> (rdata_o == MASK));
  p_prog_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog |=> prog);
endmodule

// File: tb/bar_window_tb_top.sv
`timescale 1ns/1ps
module bar_window_tb_top;
  localparam int unsigned SL = 16;
  localparam logic [31:0] MASK = 32'hFFFF_0000;
  localparam logic [31:0] SZ = 32'h1 << SL;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0, we_i = 1'b0;
  logic [31:0] wdata_i = '0, bus_addr_i = '0;
  logic [31:0] rdata_o, offset_o;
  logic        hit_o;

  int unsigned n_chk = 0, n_err = 0;
  logic [31:0] m_base;
  logic        m_prog;
  bit          done = 0;

  always #2 clk_i = ~clk_i;

  bar_window #(.SIZE_LOG2(SL)) dut_i (.*);

  function automatic logic exp_hit(input logic [31:0] a);
    return m_prog && ((a & MASK) == m_base);
  endfunction
  function automatic logic [31:0] exp_off(input logic [31:0] a);
    return exp_hit(a) ? (a & ~MASK) : 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_base = MASK; m_prog = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic cycle(input logic s, input logic w, input logic [31:0] d);
    @(negedge clk_i);
    sel_i = s; we_i = w; wdata_i = d;
    @(negedge clk_i);
    if (s && w) begin m_base = d & MASK; m_prog = 1'b1; end
    sel_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic probe(input string req, input logic [31:0] a);
    bus_addr_i = a;
    #1;
    chk({req, " hit"}, {31'b0, hit_o}, {31'b0, exp_hit(a)});
    chk({req, " off"}, offset_o, exp_off(a));
  endtask

  initial begin
    logic [31:0] b;
    void'($urandom(32'h5eed));
    m_base = MASK; m_prog = 1'b0;
    bus_addr_i = MASK;
    do_reset();
    #1;
    chk("R1 reset mask", rdata_o, MASK);
    chk("R5 no hit before write", {31'b0, hit_o}, 32'h0);
    probe("R5 unprog", 32'hFFFF_0010);

    // partial strobes must not write
    cycle(1'b1, 1'b0, 32'h1234_5678);
    chk("R2 we low ignored", rdata_o, MASK);
    cycle(1'b0, 1'b1, 32'h1234_5678);
    chk("R2 sel low ignored", rdata_o, MASK);
    probe("R5 still unprog", 32'h1234_0000);

    // unaligned write
    cycle(1'b1, 1'b1, 32'hA5A5_BEEF);
    chk("R3 low bits zero", rdata_o, 32'hA5A5_0000);
    chk("R4 base read back", rdata_o, m_base);
    probe("R6 first byte", 32'hA5A5_0000);
    chk("R6 first byte hit", {31'b0, hit_o}, 32'h1);
    probe("R7 last byte", 32'hA5A5_FFFF);
    chk("R7 last offset", offset_o, 32'h0000_FFFF);
    probe("R6 one past", 32'hA5A6_0000);
    chk("R6 one past miss", {31'b0, hit_o}, 32'h0);
    probe("R6 one below", 32'hA5A4_FFFF);

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic s, w;
      s = ($urandom % 4) != 0;
      w = ($urandom % 3) != 0;
      cycle(s, w, $urandom);
      chk("R4 R3 readback", rdata_o, m_base);
      b = m_base;
      case ($urandom % 5)
        0: probe("R6 rnd first", b);
        1: probe("R7 rnd last", b + SZ - 1);
        2: probe("R6 rnd past", b + SZ);
        3: probe("R6 rnd below", b - 1);
        default: probe("R7 rnd any", $urandom);
      endcase
    end

    // second reset with matching address held
    cycle(1'b1, 1'b1, 32'h0042_0000);
    bus_addr_i = 32'h0042_0100;
    #1;
    chk("R6 pre-reset hit", {31'b0, hit_o}, 32'h1);
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_base = MASK; m_prog = 1'b0;
    #1;
    chk("R8 mask restored", rdata_o, MASK);
    chk("R8 hit cleared", {31'b0, hit_o}, 32'h0);
    chk("R8 offset cleared", offset_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    probe("R8 mask addr after reset", MASK);
    cycle(1'b1, 1'b0, 32'h0);
    chk("R1 mask after second reset", rdata_o, MASK);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule